// File: doc/BRIEF.md
# Bank Select Memory Manager

This block sits between an 8-bit CPU with a 64K address space and a larger physical memory built from up to sixteen 64K banks. The CPU selects a bank by writing to one I/O port whose address is set by configuration. The block holds the selected bank in a small register. It translates every CPU address into a physical bank number, which drives the physical address lines above the 64K boundary.

A configurable region at the top of the CPU space is shared by all banks. It always resolves to physical bank 0, so code and data placed there stay visible whatever bank is selected. The bank register can be decoded two ways:

- One-hot: at most one bit may be set, which reaches four banks plus bank 0.
- Encoded: the four bits are a binary bank number, which reaches all sixteen banks.

From reset until the first write to the port, the block stays in a start-up state. In that state every address maps to the lowest bank, and a flag tells the memory decoder that boot ROM may overlay RAM.

Top module: `bank_mmu`

## Requirements
- R1: While reset is asserted and after it is released, `rom_bank` is 1, `sel_invalid` is 0 and `phys_bank` is 0 for every CPU address.
- R2: A write is accepted only when `io_wr` is 1 at a rising clock edge and `io_port` equals `cfg_port`. Only `io_data[3:0]` is used. Writes to any other port change no output, and `io_data[7:4]` has no effect.
- R3: The first accepted write clears `rom_bank`, whatever its data. `rom_bank` then stays 0 until the next reset.
- R4: With `cfg_encoded` = 0 (one-hot), a stored value with only bit n set gives physical bank n+1, so 04h gives bank 3. A stored value of zero gives bank 0.
- R5: With `cfg_encoded` = 0, a write with more than one of `io_data[3:0]` set sets `sel_invalid` to 1 and leaves the previous bank selection in force.
- R6: Any accepted write that is stored clears `sel_invalid` to 0.
- R7: With `cfg_encoded` = 1, any value N from 0 to 15 is accepted and gives physical bank N. A write in this mode never sets `sel_invalid`.
- R8: The common region is the top (`cfg_common`+1)×8K of the CPU space, so 00 gives 8K, 01 gives 16K, 10 gives 24K and 11 gives 32K. Every address inside it gives `phys_bank` 0. Addresses below it give the selected bank.
- R9: A write takes effect on the outputs right after the clock edge that accepts it, and not before that edge. Translation of `cpu_addr` is combinational, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, sampled at the rising edge |
| io_port | input | 8 | I/O port address of the current cycle |
| io_data | input | 8 | CPU data bus during an I/O write |
| cfg_port | input | 8 | Port address that the bank register answers to |
| cfg_encoded | input | 1 | 0 = one-hot decode, 1 = binary decode |
| cfg_common | input | 2 | Common region size code, in 8K steps minus one |
| cpu_addr | input | 16 | CPU logical address |
| phys_bank | output | 4 | Physical bank number for the address lines above 64K |
| rom_bank | output | 1 | High in the start-up state, before any port write |
| sel_invalid | output | 1 | High when the last write was a rejected one-hot value |

## Verification
The bench builds the block with its default parameters: 16 address bits, four select bits, a 4-bit bank number and 8K common granularity. With these values every one-hot and encoded register value can be reached, and all four common sizes can be tried.

The bench tests the common region at the addresses on each side of every boundary. It runs the decode modes in separate reset epochs, so the start-up state is seen ending under both modes.

A behavioural model in the bench follows the register on every cycle. Against it, the bench checks rejected multi-bit writes, writes to other ports, upper data bits, and the one-cycle delay of the register.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

   // decode style of the bank register
   typedef enum logic {
      DEC_ONEHOT  = 1'b0,
      DEC_ENCODED = 1'b1
   } dec_mode_e;

   // true when more than one bit of a value is set
   function automatic logic multi_hot(input logic [31:0] v);
      return (v & (v - 32'd1)) != 32'd0;
   endfunction

endpackage

// File: rtl/bmm_port_reg.sv
module bmm_port_reg
   import bmm_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] io_port,
   input  logic [DATA_W-1:0] io_data,
   input  logic [PORT_W-1:0] cfg_port,
   input  dec_mode_e         mode,
   output logic [SEL_W-1:0]  sel_q,
   output logic              boot_q,
   output logic              bad_q
);

   logic             hit;
   logic [SEL_W-1:0] nib;
   logic             reject;

   assign hit    = io_wr && (io_port == cfg_port);
   assign nib    = io_data[SEL_W-1:0];
   assign reject = (mode == DEC_ONEHOT) && multi_hot(32'(nib));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         boot_q <= 1'b1;
         bad_q  <= 1'b0;
      end else if (hit) begin
         boot_q <= 1'b0;
         bad_q  <= reject;
         if (!reject) sel_q <= nib;
      end
   end

endmodule

// File: rtl/bmm_sel_decode.sv
module bmm_sel_decode
   import bmm_pkg::*;
#(
   parameter int SEL_W  = 4,
   parameter int BANK_W = 4
) (
   input  logic [SEL_W-1:0]  sel,
   input  dec_mode_e         mode,
   output logic [BANK_W-1:0] bank
);

   logic [BANK_W-1:0] enc_bank;
   logic [BANK_W-1:0] hot_bank;

   // binary decode: zero extend when the bank field is wider
   if (BANK_W > SEL_W) begin : g_ext
      assign enc_bank = {{(BANK_W-SEL_W){1'b0}}, sel};
   end else begin : g_same
      assign enc_bank = sel[BANK_W-1:0];
   end

   // one-hot decode: lowest set bit n gives bank n+1
   logic [BANK_W-1:0] cand [SEL_W+1];
   assign cand[SEL_W] = '0;
   for (genvar i = SEL_W - 1; i >= 0; i--) begin : g_hot
      assign cand[i] = sel[i] ? BANK_W'(i + 1) : cand[i+1];
   end
   assign hot_bank = cand[0];

   assign bank = (mode == DEC_ENCODED) ? enc_bank : hot_bank;

endmodule

// File: rtl/bmm_common_detect.sv
module bmm_common_detect #(
   parameter int ADDR_W = 16,
   parameter int SEG_W  = 3,
   parameter int CS_W   = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CS_W-1:0]   size_code,
   output logic              in_common
);

   localparam int NSEG = 1 << SEG_W;

   logic [SEG_W-1:0] seg;
   logic [SEG_W:0]   floor_seg;

   assign seg       = addr[ADDR_W-1 -: SEG_W];
   // first segment of the shared region: NSEG - (code + 1)
   assign floor_seg = (SEG_W+1)'(NSEG) - (SEG_W+1)'(size_code) - (SEG_W+1)'(1);
   assign in_common = {1'b0, seg} >= floor_seg;

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
   import bmm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8,
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4,
   parameter int BANK_W = 4,
   parameter int SEG_W  = 3,
   parameter int CS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] io_port,
   input  logic [DATA_W-1:0] io_data,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic              cfg_encoded,
   input  logic [CS_W-1:0]   cfg_common,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic [BANK_W-1:0] phys_bank,
   output logic              rom_bank,
   output logic              sel_invalid
);

   // elaboration-time parameter checks
   if (SEL_W > DATA_W) begin : g_bad_data
      $error("bank_mmu: SEL_W exceeds DATA_W");
   end
   if (SEL_W > BANK_W) begin : g_bad_bank
      $error("bank_mmu: encoded selection does not fit BANK_W");
   end
   if (SEG_W >= ADDR_W) begin : g_bad_seg
      $error("bank_mmu: SEG_W must be below ADDR_W");
   end
   if ((1 << CS_W) > (1 << SEG_W)) begin : g_bad_cs
      $error("bank_mmu: common size code exceeds segment count");
   end

   dec_mode_e         mode;
   logic [SEL_W-1:0]  sel_q;
   logic              boot_q;
   logic              bad_q;
   logic [BANK_W-1:0] sel_bank;
   logic              in_common;

   assign mode = cfg_encoded ? DEC_ENCODED : DEC_ONEHOT;

   bmm_port_reg #(
      .PORT_W(PORT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_wr   (io_wr),
      .io_port (io_port),
      .io_data (io_data),
      .cfg_port(cfg_port),
      .mode    (mode),
      .sel_q   (sel_q),
      .boot_q  (boot_q),
      .bad_q   (bad_q)
   );

   bmm_sel_decode #(
      .SEL_W(SEL_W), .BANK_W(BANK_W)
   ) u_dec (
      .sel (sel_q),
      .mode(mode),
      .bank(sel_bank)
   );

   bmm_common_detect #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CS_W(CS_W)
   ) u_common (
      .addr     (cpu_addr),
      .size_code(cfg_common),
      .in_common(in_common)
   );

   assign phys_bank   = (boot_q || in_common) ? '0 : sel_bank;
   assign rom_bank    = boot_q;
   assign sel_invalid = bad_q;

endmodule

// File: rtl/bmm_checker.sv
module bmm_checker #(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8,
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4,
   parameter int BANK_W = 4,
   parameter int SEG_W  = 3,
   parameter int CS_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [PORT_W-1:0] io_port,
   input logic [DATA_W-1:0] io_data,
   input logic [PORT_W-1:0] cfg_port,
   input logic              cfg_encoded,
   input logic [CS_W-1:0]   cfg_common,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [BANK_W-1:0] phys_bank,
   input logic              rom_bank,
   input logic              sel_invalid,
   input logic [SEL_W-1:0]  sel_q
);

   logic hit;
   logic many;
   logic in_c;
   int   lim;

   assign hit  = io_wr && (io_port == cfg_port);
   assign many = $countones(io_data[SEL_W-1:0]) > 1;
   always_comb begin
      lim  = (1 << ADDR_W) - (int'(cfg_common) + 1) * (1 << (ADDR_W - SEG_W));
      in_c = int'(cpu_addr) >= lim;
   end

   p_boot_bank0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rom_bank |-> phys_bank == '0);

   p_foreign_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(sel_q) && $stable(rom_bank) && $stable(sel_invalid));

   p_write_ends_boot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !rom_bank);

   p_boot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_bank |=> !rom_bank);

   p_onehot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_encoded |-> int'(phys_bank) <= SEL_W);

   p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cfg_encoded && many) |=> sel_invalid && $stable(sel_q));

   p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (cfg_encoded || !many)) |=>
         !sel_invalid && sel_q == $past(io_data[SEL_W-1:0]));

   p_common_bank0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_c |-> phys_bank == '0);

endmodule

bind bank_mmu bmm_checker #(
   .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
   .BANK_W(BANK_W), .SEG_W(SEG_W), .CS_W(CS_W)
) u_bmm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_wr      (io_wr),
   .io_port    (io_port),
   .io_data    (io_data),
   .cfg_port   (cfg_port),
   .cfg_encoded(cfg_encoded),
   .cfg_common (cfg_common),
   .cpu_addr   (cpu_addr),
   .phys_bank  (phys_bank),
   .rom_bank   (rom_bank),
   .sel_invalid(sel_invalid),
   .sel_q      (sel_q)
);

// File: tb/tb_bank_mmu.sv
module tb_bank_mmu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_port = 8'h00;
   logic [7:0]  io_data = 8'h00;
   logic [7:0]  cfg_port = 8'h40;
   logic        cfg_encoded = 1'b0;
   logic [1:0]  cfg_common = 2'b00;
   logic [15:0] cpu_addr = 16'h0000;
   logic [3:0]  phys_bank;
   logic        rom_bank;
   logic        sel_invalid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_boot = 1;
   int m_sel  = 0;
   int m_bad  = 0;

   always #5 clk = ~clk;

   bank_mmu dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
      .io_data(io_data), .cfg_port(cfg_port), .cfg_encoded(cfg_encoded),
      .cfg_common(cfg_common), .cpu_addr(cpu_addr), .phys_bank(phys_bank),
      .rom_bank(rom_bank), .sel_invalid(sel_invalid)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_boot = 1; m_sel = 0; m_bad = 0;
      end else if (io_wr && io_port == cfg_port) begin
         int d;
         int n;
         d = io_data & 8'h0F;
         n = 0;
         for (int i = 0; i < 4; i++) if (d[i]) n++;
         m_boot = 0;
         if (cfg_encoded || n <= 1) begin
            m_sel = d; m_bad = 0;
         end else begin
            m_bad = 1;
         end
      end
   end

   function automatic int exp_bank(input int addr);
      if (m_boot != 0) return 0;
      if (addr >= 65536 - (int'(cfg_common) + 1) * 8192) return 0;
      if (cfg_encoded) return m_sel;
      for (int i = 0; i < 4; i++) if (m_sel == (1 << i)) return i + 1;
      return 0;
   endfunction

   task automatic compare(input string req);
      checks++;
      if (int'(phys_bank) != exp_bank(int'(cpu_addr)) ||
          int'(rom_bank) != m_boot || int'(sel_invalid) != m_bad) begin
         errors++;
         $display("FAIL %s addr=%h bank/rom/inv actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                  req, cpu_addr, phys_bank, rom_bank, sel_invalid,
                  exp_bank(int'(cpu_addr)), m_boot, m_bad);
      end
   endtask

   // drive one cycle at the falling edge, compare before the next rising edge
   task automatic step(input bit wr, input logic [7:0] port, input logic [7:0] data,
                       input logic [15:0] addr, input string req);
      @(negedge clk);
      io_wr = wr; io_port = port; io_data = data; cpu_addr = addr;
      #2;
      compare(req);
   endtask

   task automatic wr_then_check(input logic [7:0] data, input logic [15:0] addr,
                                input string req);
      step(1'b1, cfg_port, data, addr, req);  // R9: old state before the edge
      step(1'b0, 8'h00, 8'h00, addr, req);
   endtask

   task automatic do_reset(input bit enc);
      @(negedge clk);
      rst_n = 1'b0; io_wr = 1'b0; cfg_encoded = enc; cfg_common = 2'b00;
      #2;
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // ---- one-hot epoch ----
      do_reset(1'b0);
      step(1'b0, 8'h00, 8'h00, 16'h0000, "R1");
      step(1'b0, 8'h00, 8'h00, 16'hFFFF, "R1");
      step(1'b0, 8'h00, 8'h00, 16'h5000, "R1");
      // R2: foreign port write has no effect, start-up state persists
      step(1'b1, 8'h41, 8'h02, 16'h1000, "R2");
      step(1'b0, 8'h00, 8'h00, 16'h1000, "R2");
      // R3/R4/R2: upper bits ignored, F4 -> bank 3, start-up state ends
      wr_then_check(8'hF4, 16'h1000, "R3");
      wr_then_check(8'h01, 16'h2000, "R4");
      wr_then_check(8'h08, 16'h3000, "R4");
      wr_then_check(8'h00, 16'h3000, "R4");
      wr_then_check(8'h02, 16'h3000, "R4");
      // R5: multi-bit rejected, previous bank (2) kept
      wr_then_check(8'h06, 16'h3000, "R5");
      wr_then_check(8'h0F, 16'h0100, "R5");
      step(1'b1, 8'h7F, 8'h01, 16'h0100, "R2");
      step(1'b0, 8'h00, 8'h00, 16'h0100, "R2");
      // R6: valid write clears the flag
      wr_then_check(8'h08, 16'h0100, "R6");
      // R3: stays cleared after further writes
      wr_then_check(8'h00, 16'h0000, "R3");
      wr_then_check(8'h04, 16'h0000, "R3");
      // R8: every common size, both sides of its boundary
      for (int cs = 0; cs < 4; cs++) begin
         int b;
         cfg_common = 2'(cs);
         b = 65536 - (cs + 1) * 8192;
         step(1'b0, 8'h00, 8'h00, 16'(b - 1), "R8");
         step(1'b0, 8'h00, 8'h00, 16'(b), "R8");
         step(1'b0, 8'h00, 8'h00, 16'hFFFF, "R8");
         step(1'b0, 8'h00, 8'h00, 16'h7FFF, "R8");
      end
      // ---- encoded epoch ----
      do_reset(1'b1);
      step(1'b0, 8'h00, 8'h00, 16'h4000, "R1");
      cfg_common = 2'b01;
      for (int v = 0; v < 16; v++) begin
         wr_then_check(8'(8'hA0 | v), 16'h4000, "R7");
         step(1'b0, 8'h00, 8'h00, 16'hC000, "R8");
      end
      wr_then_check(8'h0A, 16'h1234, "R7");
      step(1'b1, 8'h3F, 8'h05, 16'h1234, "R2");
      step(1'b0, 8'h00, 8'h00, 16'h1234, "R2");
      cfg_common = 2'b11;
      step(1'b0, 8'h00, 8'h00, 16'h8000, "R8");
      step(1'b0, 8'h00, 8'h00, 16'h7FFF, "R8");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule